// File: doc/BRIEF.md
# PCIe Endpoint BAR Register Bank

This block keeps the six Base Address Registers of one PCIe endpoint function. Each BAR has a size mask next to it. Only the local side can write a mask, and the host never sees one. Firmware on the local side writes each BAR's kind (memory or I/O, 32-bit or 64-bit, prefetchable) and its mask through a register port. For a mask write, firmware uses the BAR's own address with bit 12 set.

The host side works through a separate configuration port. During enumeration the host writes all ones to a BAR and reads it back to learn the region size, then writes the base address it assigns. Bits covered by the mask and the type field are protected from host writes. A BAR whose mask is zero is switched off.

The BARs work in pairs (0,1), (2,3) and (4,5). A pair can act as one 64-bit BAR, as two independent 32-bit BARs, or as a single 32-bit BAR whose partner is switched off. For an incoming request address the block also reports which BARs claim it.

Top module: `pcie_bar_bank`

## Requirements
- R1: After reset every BAR reads back zero on the configuration port and no BAR reports a hit, because every mask starts at zero.
- R2: Host writes never change a BAR's type field. For a memory BAR this is bits 3:0 (0x0 32-bit, 0x8 32-bit prefetchable, 0x4 64-bit, 0xC 64-bit prefetchable). For an I/O BAR (bit 0 = 1) it is bits 1:0.
- R3: A local write at BAR offset 0x10 + 4*n with address bit 12 set loads mask n. With bit 12 clear, the same write loads BAR n and leaves the mask unchanged. The configuration port has no path to any mask.
- R4: Address bits covered by a BAR's mask read back as zero and keep their value across host writes. With mask 0xFFFF on a 32-bit memory BAR, a host write of 0xFFFFFFFF reads back as 0xFFFF0000 plus the type bits.
- R5: A BAR whose mask is zero reads back as zero and ignores host writes.
- R6: When the even BAR of a pair has a 64-bit memory type, the odd BAR becomes the upper address word. It is protected only by its own mask: with a zero mask it is fully writable and readable. It never hits on its own, and it reads zero while the lower BAR is switched off.
- R7: When the even BAR of a pair is not 64-bit, the two BARs of the pair keep separate values, masks and hits.
- R8: A BAR hits only when the request kind matches (memory request on a memory BAR, I/O request on an I/O BAR) and the address agrees with the base on every bit outside the mask and the type field.
- R9: A 64-bit BAR compares all 64 request bits against its two words. A 32-bit BAR hits only when bits 63:32 of the request are zero.
- R10: When both ports write the same BAR in one cycle, the local write's value is kept.
- R11: A host access with a BAR index of 6 or 7 reads zero and changes no BAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| loc_we | input | 1 | Local register write strobe |
| loc_addr | input | 13 | Local byte address; bit 12 selects the mask register |
| loc_wdata | input | 32 | Local write data |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_idx | input | 3 | BAR index for host read and write |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read-back of the indexed BAR |
| req_addr | input | 64 | Address of an incoming request |
| req_is_io | input | 1 | Request is I/O (1) or memory (0) |
| bar_hit | output | 6 | One bit per BAR claiming the request |

## Verification
A write on either port lands at the clock edge that samples its strobe, and the new value shows on cfg_rdata right after that edge. cfg_rdata and bar_hit are combinational functions of the stored state, cfg_idx and the request, so they follow an index or address change within the same cycle. After rst_n rises, the internal reset holds for two more edges. The bench starts no stimulus during that window. It drives on the falling edge and checks directed read-backs and hits a moment later. A behavioural model updated on each rising edge is compared with both outputs shortly after every rising edge.

// File: rtl/pcie_bar_pkg.sv
package pcie_bar_pkg;
  localparam int unsigned BAR_W = 32;
  typedef logic [BAR_W-1:0] bar_word_t;

  // read-only type field: two bits for I/O, four bits for memory
  function automatic bar_word_t type_field(input bar_word_t w);
    return w[0] ? bar_word_t'(3) : bar_word_t'(15);
  endfunction

  // memory BAR whose locatable field selects 64-bit decoding
  function automatic logic is_mem64(input bar_word_t w);
    return (!w[0]) && (w[2:1] == 2'b10);
  endfunction
endpackage

// File: rtl/bar_pair_regs.sv
module bar_pair_regs
  import pcie_bar_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            loc_bar_we,
  input  logic [1:0]            loc_msk_we,
  input  logic [1:0]            cfg_we,
  input  bar_word_t             loc_wdata,
  input  bar_word_t             cfg_wdata,
  output logic [1:0][BAR_W-1:0] rd_val,
  output logic [1:0][BAR_W-1:0] base_o,
  output logic [1:0][BAR_W-1:0] ro_o,
  output logic [1:0]            en_o,
  output logic [1:0]            io_o,
  output logic                  fused_o
);
  logic [1:0][BAR_W-1:0] base_q, base_d, mask_q, tm, ro;
  logic [1:0]            en, base_ce;
  logic                  fused;

  // pair attributes
  always_comb begin
    fused = is_mem64(base_q[0]);
    tm[0] = type_field(base_q[0]);
    tm[1] = fused ? '0 : type_field(base_q[1]);
    en[0] = |mask_q[0];
    en[1] = fused ? en[0] : |mask_q[1];
    for (int k = 0; k < 2; k++) begin
      ro[k]     = mask_q[k] | tm[k];
      rd_val[k] = en[k] ? ((base_q[k] & ~ro[k]) | (base_q[k] & tm[k])) : '0;
    end
  end

  // next state: local write has priority over host write
  always_comb begin
    for (int k = 0; k < 2; k++) begin
      base_ce[k] = loc_bar_we[k] | (cfg_we[k] & en[k]);
      if (loc_bar_we[k]) base_d[k] = loc_wdata;
      else               base_d[k] = (base_q[k] & ro[k]) | (cfg_wdata & ~ro[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (base_ce[k])    base_q[k] <= base_d[k];
        if (loc_msk_we[k]) mask_q[k] <= loc_wdata;
      end
    end
  end

  assign base_o  = base_q;
  assign ro_o    = ro;
  assign en_o    = en;
  assign io_o    = {base_q[1][0], base_q[0][0]};
  assign fused_o = fused;

  for (genvar k = 0; k < 2; k++) begin : g_chk
    // R2: host writes leave the type field alone
    a_r2_type_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we[k] && !loc_bar_we[k]) |=>
        (((base_q[k] ^ $past(base_q[k])) & $past(tm[k])) == '0));
    // R4: masked address bits survive host writes
    a_r4_masked_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we[k] && !loc_bar_we[k]) |=>
        (((base_q[k] ^ $past(base_q[k])) & $past(mask_q[k])) == '0));
    // R5: disabled BAR ignores the host
    a_r5_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we[k] && !loc_bar_we[k] && !en[k]) |=> $stable(base_q[k]));
    // R10: local write value wins
    a_r10_local_wins: assert property (@(posedge clk) disable iff (!rst_n)
      loc_bar_we[k] |=> (base_q[k] == $past(loc_wdata)));
    // R3: mask changes only by local mask write
    a_r3_mask_local_only: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_msk_we[k] |=> $stable(mask_q[k]));
  end
endmodule

// File: rtl/bar_hit_cmp.sv
module bar_hit_cmp
  import pcie_bar_pkg::*;
(
  input  logic [1:0][BAR_W-1:0] base_i,
  input  logic [1:0][BAR_W-1:0] ro_i,
  input  logic [1:0]            en_i,
  input  logic [1:0]            io_i,
  input  logic                  fused_i,
  input  logic [2*BAR_W-1:0]    req_addr,
  input  logic                  req_is_io,
  output logic [1:0]            hit
);
  localparam int unsigned AW = 2 * BAR_W;
  logic [AW-1:0] lo_base, lo_dc, hi_base, hi_dc;

  always_comb begin
    lo_base = fused_i ? {base_i[1], base_i[0]} : {{BAR_W{1'b0}}, base_i[0]};
    lo_dc   = fused_i ? {ro_i[1],   ro_i[0]}   : {{BAR_W{1'b0}}, ro_i[0]};
    hi_base = {{BAR_W{1'b0}}, base_i[1]};
    hi_dc   = {{BAR_W{1'b0}}, ro_i[1]};
    hit[0]  = en_i[0] && (io_i[0] == req_is_io)
              && (((req_addr ^ lo_base) & ~lo_dc) == '0);
    hit[1]  = !fused_i && en_i[1] && (io_i[1] == req_is_io)
              && (((req_addr ^ hi_base) & ~hi_dc) == '0);
  end
endmodule

// File: rtl/pcie_bar_bank.sv
module pcie_bar_bank
  import pcie_bar_pkg::*;
#(
  parameter  int NUM_PAIRS    = 3,
  parameter  int MASK_SEL_BIT = 12,
  parameter  int BAR_OFF      = 16,
  localparam int NUM_BARS     = 2 * NUM_PAIRS,
  localparam int CFG_IW       = $clog2(NUM_BARS)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loc_we,
  input  logic [MASK_SEL_BIT:0]   loc_addr,
  input  logic [BAR_W-1:0]        loc_wdata,
  input  logic                    cfg_we,
  input  logic [CFG_IW-1:0]       cfg_idx,
  input  logic [BAR_W-1:0]        cfg_wdata,
  output logic [BAR_W-1:0]        cfg_rdata,
  input  logic [2*BAR_W-1:0]      req_addr,
  input  logic                    req_is_io,
  output logic [NUM_BARS-1:0]     bar_hit
);
  logic [1:0]                      rst_pipe;
  logic                            rst_core_n;
  logic [NUM_BARS-1:0]             loc_bar_we, loc_msk_we, cfg_bar_we;
  logic [NUM_BARS-1:0][BAR_W-1:0]  rd_all, base_all, ro_all;
  logic [NUM_BARS-1:0]             en_all, io_all;
  logic [NUM_PAIRS-1:0]            fused;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // write strobes per BAR
  for (genvar b = 0; b < NUM_BARS; b++) begin : g_dec
    localparam logic [MASK_SEL_BIT-1:0] OFF = MASK_SEL_BIT'(BAR_OFF + 4 * b);
    logic off_hit;
    assign off_hit       = (loc_addr[MASK_SEL_BIT-1:0] == OFF);
    assign loc_bar_we[b] = loc_we && off_hit && !loc_addr[MASK_SEL_BIT];
    assign loc_msk_we[b] = loc_we && off_hit &&  loc_addr[MASK_SEL_BIT];
    assign cfg_bar_we[b] = cfg_we && (cfg_idx == CFG_IW'(b));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    bar_pair_regs i_regs (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .loc_bar_we(loc_bar_we[2*p +: 2]),
      .loc_msk_we(loc_msk_we[2*p +: 2]),
      .cfg_we    (cfg_bar_we[2*p +: 2]),
      .loc_wdata (loc_wdata),
      .cfg_wdata (cfg_wdata),
      .rd_val    (rd_all[2*p +: 2]),
      .base_o    (base_all[2*p +: 2]),
      .ro_o      (ro_all[2*p +: 2]),
      .en_o      (en_all[2*p +: 2]),
      .io_o      (io_all[2*p +: 2]),
      .fused_o   (fused[p])
    );
    bar_hit_cmp i_hit (
      .base_i   (base_all[2*p +: 2]),
      .ro_i     (ro_all[2*p +: 2]),
      .en_i     (en_all[2*p +: 2]),
      .io_i     (io_all[2*p +: 2]),
      .fused_i  (fused[p]),
      .req_addr (req_addr),
      .req_is_io(req_is_io),
      .hit      (bar_hit[2*p +: 2])
    );
    // R6: an upper word never claims a request by itself
    a_r6_upper_silent: assert property (@(posedge clk) disable iff (!rst_core_n)
      fused[p] |-> !bar_hit[2*p+1]);
    // R6: upper word reads zero while the lower BAR is off
    a_r6_upper_follows: assert property (@(posedge clk) disable iff (!rst_core_n)
      (fused[p] && (rd_all[2*p][3:0] == 4'h0)) |-> (rd_all[2*p+1] == '0));
  end

  // host read-back mux; unused indexes read zero
  always_comb begin
    cfg_rdata = '0;
    for (int b = 0; b < NUM_BARS; b++)
      if (cfg_idx == CFG_IW'(b)) cfg_rdata = rd_all[b];
  end
endmodule

// File: tb/test_pcie_bar_bank.sv
module test_pcie_bar_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        loc_we;
  logic [12:0] loc_addr;
  logic [31:0] loc_wdata;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [63:0] req_addr;
  logic        req_is_io;
  logic [5:0]  bar_hit;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] mb [6];
  logic [31:0] mm [6];

  always #4 clk = ~clk;

  pcie_bar_bank i_pcie_bar_bank (
    .clk(clk), .rst_n(rst_n), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
    .req_is_io(req_is_io), .bar_hit(bar_hit)
  );

  // ---------------- behavioural reference ----------------
  function automatic bit m_upper(int i);
    return (i % 2 == 1) && (mb[i-1][0] == 1'b0) && (mb[i-1][2:1] == 2'b10);
  endfunction
  function automatic logic [31:0] m_tf(int i);
    if (m_upper(i)) return 32'h0;
    return mb[i][0] ? 32'h3 : 32'hF;
  endfunction
  function automatic bit m_en(int i);
    if (m_upper(i)) return mm[i-1] != 0;
    return mm[i] != 0;
  endfunction
  function automatic logic [31:0] m_rd(int i);
    logic [31:0] ro;
    if (i > 5) return 32'h0;
    ro = mm[i] | m_tf(i);
    return m_en(i) ? ((mb[i] & ~ro) | (mb[i] & m_tf(i))) : 32'h0;
  endfunction
  function automatic logic [5:0] m_hit(logic [63:0] a, logic io);
    logic [5:0]  h;
    logic [63:0] b, dc;
    h = '0;
    for (int i = 0; i < 6; i++) begin
      if (m_upper(i) || !m_en(i) || (mb[i][0] != io)) continue;
      if (i % 2 == 0 && m_upper(i + 1)) begin
        b  = {mb[i+1], mb[i]};
        dc = {mm[i+1], mm[i] | m_tf(i)};
      end else begin
        b  = {32'h0, mb[i]};
        dc = {32'h0, mm[i] | m_tf(i)};
      end
      if (((a ^ b) & ~dc) == 64'h0) h[i] = 1'b1;
    end
    return h;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model update on the edge, compare shortly after
  always @(posedge clk) begin
    logic [31:0] nb [6];
    logic [31:0] nm [6];
    logic [31:0] ro;
    bit          lhit;
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin mb[i] = 0; mm[i] = 0; end
    end else begin
      for (int i = 0; i < 6; i++) begin nb[i] = mb[i]; nm[i] = mm[i]; end
      for (int i = 0; i < 6; i++) begin
        lhit = loc_we && (loc_addr[11:0] == 12'(16 + 4 * i));
        ro   = mm[i] | m_tf(i);
        if (lhit && loc_addr[12])  nm[i] = loc_wdata;
        if (lhit && !loc_addr[12]) nb[i] = loc_wdata;
        else if (cfg_we && cfg_idx == 3'(i) && m_en(i))
          nb[i] = (mb[i] & ro) | (cfg_wdata & ~ro);
      end
      for (int i = 0; i < 6; i++) begin mb[i] = nb[i]; mm[i] = nm[i]; end
    end
    #2;
    chk("model R4 read-back", {32'h0, cfg_rdata}, {32'h0, m_rd(int'(cfg_idx))});
    chk("model R8 hit", {58'h0, bar_hit}, {58'h0, m_hit(req_addr, req_is_io)});
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic loc_wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk); loc_we = 1; loc_addr = a; loc_wdata = d;
    @(negedge clk); loc_we = 0;
  endtask
  task automatic cfg_wr(logic [2:0] i, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_idx = i; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic rd_chk(logic [2:0] i, logic [31:0] exp, string tag);
    @(negedge clk); cfg_idx = i; #1;
    chk(tag, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask
  task automatic hit_chk(logic [63:0] a, logic io, logic [5:0] exp, string tag);
    @(negedge clk); req_addr = a; req_is_io = io; #1;
    chk(tag, {58'h0, bar_hit}, {58'h0, exp});
  endtask

  initial begin
    rst_n = 0; loc_we = 0; loc_addr = 0; loc_wdata = 0;
    cfg_we = 0; cfg_idx = 0; cfg_wdata = 0; req_addr = 0; req_is_io = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int i = 0; i < 6; i++) rd_chk(3'(i), 32'h0, "R1 reset read");
    hit_chk(64'h0, 1'b0, 6'h0, "R1 no memory hit");
    hit_chk(64'h0, 1'b1, 6'h0, "R1 no io hit");

    // R4 sizing with mask 0xFFFF
    loc_wr(13'h1010, 32'h0000_FFFF);
    loc_wr(13'h0010, 32'h0);
    cfg_wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'hFFFF_0000, "R4 sizing read-back");

    // R3 plain address write keeps the mask; R2 type kept
    loc_wr(13'h0010, 32'h8);
    cfg_wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'hFFFF_0008, "R3 mask kept after plain write");
    cfg_wr(0, 32'h0);
    rd_chk(0, 32'h0000_0008, "R2 type bits survive host write");

    // R7 independent partner
    loc_wr(13'h1014, 32'h0000_0FFF);
    loc_wr(13'h0014, 32'h0);
    cfg_wr(1, 32'hFFFF_FFFF);
    rd_chk(1, 32'hFFFF_F000, "R7 partner sized alone");
    rd_chk(0, 32'h0000_0008, "R7 even BAR untouched");

    // R8 / R9 decode
    cfg_wr(0, 32'h1234_5678);
    rd_chk(0, 32'h1234_0008, "R4 base assigned");
    cfg_wr(1, 32'hABCD_E123);
    rd_chk(1, 32'hABCD_E000, "R4 partner base");
    hit_chk(64'h0000_0000_1234_5678, 1'b0, 6'b000001, "R8 hit BAR0");
    hit_chk(64'h0000_0000_ABCD_EFFF, 1'b0, 6'b000010, "R8 hit BAR1");
    hit_chk(64'h0000_0000_1234_5678, 1'b1, 6'b000000, "R8 io vs memory");
    hit_chk(64'h0000_0000_1235_0000, 1'b0, 6'b000000, "R8 outside");
    hit_chk(64'h0000_0001_1234_5678, 1'b0, 6'b000000, "R9 32-bit needs zero upper");

    // R5 zero mask
    loc_wr(13'h0018, 32'h1);
    cfg_wr(2, 32'hFFFF_FFFF);
    rd_chk(2, 32'h0, "R5 disabled read");
    rd_chk(3, 32'h0, "R5 partner disabled");

    // R2 I/O BAR
    loc_wr(13'h1018, 32'h0000_00FF);
    cfg_wr(2, 32'hFFFF_FFFF);
    rd_chk(2, 32'hFFFF_FF01, "R2 io sizing");
    cfg_wr(2, 32'h0000_C0AB);
    rd_chk(2, 32'h0000_C001, "R2 io base");
    hit_chk(64'h0000_0000_0000_C0FF, 1'b1, 6'b000100, "R8 io hit");
    hit_chk(64'h0000_0000_0000_C0FF, 1'b0, 6'b000000, "R8 memory miss on io");

    // R6 64-bit pair
    loc_wr(13'h1020, 32'h000F_FFFF);
    loc_wr(13'h0020, 32'hC);
    loc_wr(13'h1024, 32'h0);
    cfg_wr(4, 32'hFFFF_FFFF);
    rd_chk(4, 32'hFFF0_000C, "R6 lower sizing");
    cfg_wr(5, 32'hFFFF_FFFF);
    rd_chk(5, 32'hFFFF_FFFF, "R6 upper writable");
    cfg_wr(4, 32'h8000_0000);
    cfg_wr(5, 32'h0000_0002);
    rd_chk(4, 32'h8000_000C, "R6 lower base");
    rd_chk(5, 32'h0000_0002, "R6 upper base");
    hit_chk(64'h0000_0002_8000_1234, 1'b0, 6'b010000, "R9 64-bit hit");
    hit_chk(64'h0000_0000_8000_1234, 1'b0, 6'b000000, "R9 upper mismatch");
    hit_chk(64'h0000_0002_8010_0000, 1'b0, 6'b000000, "R9 outside window");
    loc_wr(13'h1020, 32'h0);
    rd_chk(4, 32'h0, "R6 lower disabled");
    rd_chk(5, 32'h0, "R6 upper follows lower");

    // R10 collision
    @(negedge clk);
    loc_we = 1; loc_addr = 13'h0014; loc_wdata = 32'h7777_7008;
    cfg_we = 1; cfg_idx = 3'd1; cfg_wdata = 32'h5555_5000;
    @(negedge clk); loc_we = 0; cfg_we = 0;
    rd_chk(1, 32'h7777_7008, "R10 local wins");

    // R11 unused index
    cfg_wr(6, 32'hFFFF_FFFF);
    rd_chk(6, 32'h0, "R11 index 6 reads zero");
    rd_chk(7, 32'h0, "R11 index 7 reads zero");
    rd_chk(0, 32'h1234_0008, "R11 BAR0 unchanged");

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule